// File: doc/BRIEF.md
# Interrupt Priority and In-Service Tracker

This block holds the interrupt state of one processor. Three 256-entry bitmaps record the vectors that are requested, the vectors that are in service, and the requested vectors that were delivered level-triggered. Requests arrive with a vector number and a level/edge flag. When the global enable is low, requests are refused. The block computes the processor priority from an 8-bit task priority and the highest in-service vector. It also offers the highest requested vector as deliverable, but only when that vector's 16-vector priority class is above the class of the highest in-service vector.

The interrupt controller uses the block in a fixed loop. When the block offers a vector, the controller acknowledges it, and the block moves the vector from requested to in service. When the handler finishes, software signals end-of-interrupt, and the block retires the highest in-service vector. If the retired vector was level-triggered, the block drives a one-cycle broadcast pulse carrying that vector, so that the upstream interrupt sources can re-arm.

Top module: `irq_prio_tracker`

## Requirements
- R1: After reset all three bitmaps and the task priority are zero, so `proc_prio` reads 0x00, `pend_valid` is 0 and `eoi_bcast_valid` is 0.
- R2: `pend_vector` is the highest-numbered requested vector, found by searching from 255 downward.
- R3: `proc_prio` equals the 8-bit task priority when bits [7:4] of the task priority are greater than or equal to bits [7:4] of the highest in-service vector. Otherwise it equals that in-service vector with bits [3:0] cleared.
- R4: An empty in-service set counts as vector 0 in both the priority and the deliverability comparisons. As a result, a requested vector in class 0 (0x00 to 0x0F) is never offered.
- R5: `pend_valid` is 1 only when `enable` is 1, at least one vector is requested, and bits [7:4] of the highest requested vector are strictly greater than bits [7:4] of the highest in-service vector. The task priority does not gate this output.
- R6: An acknowledge of vector V sets in-service bit V and clears requested bit V.
- R7: An end-of-interrupt clears the highest in-service bit. If that vector's trigger-mode bit is set, the block clears the bit and drives `eoi_bcast_valid` high for one cycle, with the vector on `eoi_bcast_vector`, on the cycle after the end-of-interrupt. An end-of-interrupt with nothing in service has no effect.
- R8: A level request (`req_level`=1) for a vector whose requested bit is already set is dropped and does not set the trigger-mode bit. An edge request sets the requested bit and leaves the trigger-mode bit unchanged.
- R9: A task-priority write keeps only bits [7:0] of `tpr_wdata`.
- R10: While `enable` is 0, requests are dropped and leave the requested bitmap unchanged.
- R11: When a request, an acknowledge and an end-of-interrupt arrive in the same cycle, they are applied in that order, and each one sees the result of the one before it.
- R12: `proc_prio`, `pend_valid` and `pend_vector` are combinational from the registered state and `enable`. Requests, acknowledges, end-of-interrupts and task-priority writes take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global enable; gates request acceptance and offering |
| req_valid | input | 1 | Interrupt request strobe |
| req_vector | input | 8 | Requested vector number |
| req_level | input | 1 | 1 = level-triggered request, 0 = edge |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_vector | input | 8 | Vector being acknowledged |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 32 | Task-priority write data; only bits [7:0] kept |
| proc_prio | output | 8 | Processor priority |
| pend_valid | output | 1 | A deliverable vector is pending |
| pend_vector | output | 8 | Highest requested vector |
| eoi_bcast_valid | output | 1 | Level end-of-interrupt pulse |
| eoi_bcast_vector | output | 8 | Vector of the level end-of-interrupt |

## Verification
The bench runs the request-offer-acknowledge-retire loop with several vector mixes:
- Scattered vectors in different classes show that the downward search picks the top bit rather than the newest or the lowest.
- A class-0 request with an empty in-service set separates a strict class comparison from a greater-or-equal one.
- A vector in the same class as the in-service vector separates a class comparison from a full 8-bit comparison.
- Task-priority values both above and below the in-service class exercise both arms of the priority formula.
- Edge, level and duplicate-level requests, each followed by an end-of-interrupt, show whether the trigger-mode bit was recorded.
- A single cycle carrying a request, an acknowledge and an end-of-interrupt for the same vector shows the order in which the three are applied.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

  parameter int VEC_W     = 8;
  parameter int NUM_VEC   = 1 << VEC_W;
  parameter int CLASS_LSB = 4;

  typedef logic [VEC_W-1:0]   vec_t;
  typedef logic [NUM_VEC-1:0] vmap_t;

  // Priority class of a vector (upper bits above CLASS_LSB).
  function automatic logic [VEC_W-CLASS_LSB-1:0] class_of(vec_t v);
    return v[VEC_W-1:CLASS_LSB];
  endfunction

  // Processor priority from task priority and top in-service vector.
  function automatic vec_t prio_of(vec_t tpr, vec_t svc_top);
    vec_t res;
    if (class_of(tpr) >= class_of(svc_top)) res = tpr;
    else res = {class_of(svc_top), {CLASS_LSB{1'b0}}};
    return res;
  endfunction

  // A request is deliverable only when its class beats the in-service class.
  function automatic logic beats(vec_t req_top, vec_t svc_top);
    return class_of(req_top) > class_of(svc_top);
  endfunction

endpackage

// File: rtl/irq_top_find.sv
module irq_top_find
  import irq_trk_pkg::*;
#(
  parameter int N = NUM_VEC,
  parameter int W = VEC_W
) (
  input  logic [N-1:0] map,
  output logic         found,
  output logic [W-1:0] idx
);
  // Ascending scan: the last hit is the highest set bit.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (map[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_eval.sv
module irq_prio_eval
  import irq_trk_pkg::*;
(
  input  logic enable,
  input  vec_t tpr,
  input  logic svc_found,
  input  vec_t svc_idx,
  input  logic req_found,
  input  vec_t req_idx,
  output vec_t proc_prio,
  output logic offer
);
  vec_t svc_eff;

  always_comb begin
    svc_eff   = svc_found ? svc_idx : '0;
    proc_prio = prio_of(tpr, svc_eff);
    offer     = enable && req_found && beats(req_idx, svc_eff);
  end
endmodule

// File: rtl/irq_bitmap_update.sv
module irq_bitmap_update
  import irq_trk_pkg::*;
(
  input  logic  enable,
  input  vmap_t req_map,
  input  vmap_t svc_map,
  input  vmap_t trig_map,
  input  logic  req_valid,
  input  vec_t  req_vector,
  input  logic  req_level,
  input  logic  ack_valid,
  input  vec_t  ack_vector,
  input  logic  eoi_valid,
  output vmap_t req_next,
  output vmap_t svc_next,
  output vmap_t trig_next,
  output logic  req_taken,
  output logic  eoi_hit,
  output logic  eoi_level,
  output vec_t  eoi_vec
);
  vmap_t req_a, trig_a, req_b, svc_b;
  logic  svc_b_found;
  vec_t  svc_b_top;

  // Stage 1: request.
  always_comb begin
    req_taken = req_valid && enable && !(req_level && req_map[req_vector]);
    req_a     = req_map;
    trig_a    = trig_map;
    if (req_taken) begin
      req_a[req_vector] = 1'b1;
      if (req_level) trig_a[req_vector] = 1'b1;
    end
  end

  // Stage 2: acknowledge sees the request result.
  always_comb begin
    req_b = req_a;
    svc_b = svc_map;
    if (ack_valid) begin
      svc_b[ack_vector] = 1'b1;
      req_b[ack_vector] = 1'b0;
    end
  end

  irq_top_find #(.N(NUM_VEC), .W(VEC_W)) u_eoi_find (
    .map(svc_b), .found(svc_b_found), .idx(svc_b_top)
  );

  // Stage 3: end-of-interrupt sees the acknowledge result.
  always_comb begin
    eoi_hit   = eoi_valid && svc_b_found;
    eoi_vec   = svc_b_top;
    eoi_level = eoi_hit && trig_a[svc_b_top];
    req_next  = req_b;
    svc_next  = svc_b;
    trig_next = trig_a;
    if (eoi_hit) svc_next[svc_b_top] = 1'b0;
    if (eoi_level) trig_next[svc_b_top] = 1'b0;
  end
endmodule

// File: rtl/irq_prio_tracker.sv
module irq_prio_tracker
  import irq_trk_pkg::*;
#(
  parameter int TPR_BUS_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 req_valid,
  input  logic [VEC_W-1:0]     req_vector,
  input  logic                 req_level,
  input  logic                 ack_valid,
  input  logic [VEC_W-1:0]     ack_vector,
  input  logic                 eoi_valid,
  input  logic                 tpr_wr,
  input  logic [TPR_BUS_W-1:0] tpr_wdata,
  output logic [VEC_W-1:0]     proc_prio,
  output logic                 pend_valid,
  output logic [VEC_W-1:0]     pend_vector,
  output logic                 eoi_bcast_valid,
  output logic [VEC_W-1:0]     eoi_bcast_vector
);
  vmap_t req_q, svc_q, trig_q;
  vmap_t req_d, svc_d, trig_d;
  vec_t  tpr_q;
  logic  req_taken, eoi_hit, eoi_level;
  vec_t  eoi_vec;
  logic  req_found, svc_found;
  vec_t  req_top, svc_top;

  irq_top_find #(.N(NUM_VEC), .W(VEC_W)) u_req_find (
    .map(req_q), .found(req_found), .idx(req_top)
  );
  irq_top_find #(.N(NUM_VEC), .W(VEC_W)) u_svc_find (
    .map(svc_q), .found(svc_found), .idx(svc_top)
  );

  irq_prio_eval u_eval (
    .enable(enable), .tpr(tpr_q),
    .svc_found(svc_found), .svc_idx(svc_top),
    .req_found(req_found), .req_idx(req_top),
    .proc_prio(proc_prio), .offer(pend_valid)
  );
  assign pend_vector = req_top;

  irq_bitmap_update u_upd (
    .enable(enable), .req_map(req_q), .svc_map(svc_q), .trig_map(trig_q),
    .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
    .ack_valid(ack_valid), .ack_vector(ack_vector), .eoi_valid(eoi_valid),
    .req_next(req_d), .svc_next(svc_d), .trig_next(trig_d),
    .req_taken(req_taken), .eoi_hit(eoi_hit), .eoi_level(eoi_level),
    .eoi_vec(eoi_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q            <= '0;
      svc_q            <= '0;
      trig_q           <= '0;
      tpr_q            <= '0;
      eoi_bcast_valid  <= 1'b0;
      eoi_bcast_vector <= '0;
    end else begin
      req_q           <= req_d;
      svc_q           <= svc_d;
      trig_q          <= trig_d;
      eoi_bcast_valid <= eoi_level;
      if (eoi_level) eoi_bcast_vector <= eoi_vec;
      if (tpr_wr) tpr_q <= tpr_wdata[VEC_W-1:0];
    end
  end

  // R3: priority never falls below the task priority.
  assert_prio_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    proc_prio >= tpr_q);

  // R5: offered vector needs enable and a live requested bit.
  assert_offer_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (enable && req_q[pend_vector]));

  // R6: acknowledge moves the vector into service.
  assert_ack_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !eoi_valid) |=> (svc_q[$past(ack_vector)] && !req_q[$past(ack_vector)]));

  // R7: broadcast pulse only follows an end-of-interrupt.
  assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast_valid |-> $past(eoi_valid));

  // R8: duplicate level request is refused by the update stage.
  assert_dup_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_level && req_q[req_vector]) |-> !req_taken);

  // R9: only the low byte of a write lands.
  assert_tpr_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tpr_wr |=> (tpr_q == $past(tpr_wdata[VEC_W-1:0])));

  // R10: nothing new is requested while disabled.
  assert_disabled_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ((req_q & ~$past(req_q)) == '0));

  // R7: an end-of-interrupt on an empty set retires nothing.
  assert_empty_eoi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !ack_valid && svc_q == '0) |-> !eoi_hit);
endmodule

// File: tb/irq_prio_tracker_tb.sv
`timescale 1ns/100ps
module irq_prio_tracker_tb;
  logic clk = 0, rst_n = 0, enable = 0;
  logic req_valid = 0, req_level = 0, ack_valid = 0, eoi_valid = 0, tpr_wr = 0;
  logic [7:0] req_vector = 0, ack_vector = 0;
  logic [31:0] tpr_wdata = 0;
  logic [7:0] proc_prio, pend_vector, eoi_bcast_vector;
  logic pend_valid, eoi_bcast_valid;

  always #2 clk = ~clk;

  irq_prio_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
    .ack_valid(ack_valid), .ack_vector(ack_vector), .eoi_valid(eoi_valid),
    .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
    .proc_prio(proc_prio), .pend_valid(pend_valid), .pend_vector(pend_vector),
    .eoi_bcast_valid(eoi_bcast_valid), .eoi_bcast_vector(eoi_bcast_vector)
  );

  typedef struct {
    string    tag;
    bit [7:0] prio;
    bit       pv;
    bit [7:0] pvec;
    bit       bv;
    bit [7:0] bvec;
  } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit [255:0] m_req = 0, m_svc = 0, m_trig = 0;
  bit [7:0] m_tpr = 0, m_bvec = 0;
  bit m_bv = 0;

  // staged one-shot stimulus
  bit s_rq, s_rl, s_ak, s_eo, s_tw;
  bit [7:0] s_rv, s_av;
  bit [31:0] s_td;

  function automatic int top_of(bit [255:0] m);
    for (int i = 255; i >= 0; i--) if (m[i]) return i;
    return -1;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pop expected items and compare with the outputs
  always @(posedge clk) begin
    #1;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      cmp(e.tag, "proc_prio", proc_prio, e.prio);
      cmp(e.tag, "pend_valid", pend_valid, e.pv);
      if (e.pv) cmp(e.tag, "pend_vector", pend_vector, e.pvec);
      cmp(e.tag, "eoi_bcast_valid", eoi_bcast_valid, e.bv);
      if (e.bv) cmp(e.tag, "eoi_bcast_vector", eoi_bcast_vector, e.bvec);
    end
  end

  // driver: apply staged stimulus for one cycle, update model, push expectation
  task automatic step(string tag);
    exp_t e;
    int s, r, st;
    @(negedge clk);
    req_valid = s_rq; req_vector = s_rv; req_level = s_rl;
    ack_valid = s_ak; ack_vector = s_av; eoi_valid = s_eo;
    tpr_wr = s_tw; tpr_wdata = s_td;
    @(posedge clk);
    #0.5;
    if (rst_n) begin
      m_bv = 0;
      if (s_rq && enable && !(s_rl && m_req[s_rv])) begin
        m_req[s_rv] = 1;
        if (s_rl) m_trig[s_rv] = 1;
      end
      if (s_ak) begin m_svc[s_av] = 1; m_req[s_av] = 0; end
      if (s_eo) begin
        st = top_of(m_svc);
        if (st >= 0) begin
          m_svc[st] = 0;
          if (m_trig[st]) begin m_trig[st] = 0; m_bv = 1; m_bvec = st[7:0]; end
        end
      end
      if (s_tw) m_tpr = s_td[7:0];
    end
    s = top_of(m_svc); if (s < 0) s = 0;
    r = top_of(m_req);
    e.tag  = tag;
    e.prio = ((m_tpr >> 4) >= (s >> 4)) ? m_tpr : 8'((s >> 4) << 4);
    e.pv   = enable && (r >= 0) && ((r >> 4) > (s >> 4));
    e.pvec = (r >= 0) ? r[7:0] : 8'h0;
    e.bv   = m_bv;
    e.bvec = m_bvec;
    sb.push_back(e);
    s_rq = 0; s_rl = 0; s_ak = 0; s_eo = 0; s_tw = 0;
  endtask

  task automatic rq(bit [7:0] v, bit lvl); s_rq = 1; s_rv = v; s_rl = lvl; endtask
  task automatic ak(bit [7:0] v); s_ak = 1; s_av = v; endtask
  task automatic tw(bit [31:0] d); s_tw = 1; s_td = d; endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    s_rq = 0; s_rl = 0; s_ak = 0; s_eo = 0; s_tw = 0; s_rv = 0; s_av = 0; s_td = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    step("R1 reset state");
    s_eo = 1; step("R7 empty eoi no effect");
    step("R7 empty eoi idle");
    enable = 1;
    rq(8'h0A, 0); step("R4 class0 request");
    step("R4 class0 not offered");
    tw(32'h1234_5678); step("R9 tpr low byte");
    enable = 0;
    rq(8'h40, 0); step("R10 request while disabled");
    enable = 1; step("R10 dropped request absent");
    rq(8'h35, 0); step("R2 req 35");
    rq(8'h90, 0); step("R2 req 90");
    rq(8'h52, 0); step("R2 req 52 top stays 90");
    ak(8'h90); step("R6 R12 ack 90");
    step("R3 isr class above tpr");
    tw(32'hFFFF_FFA3); step("R3 tpr class above isr");
    rq(8'h95, 0); step("R5 same class not offered");
    enable = 0; step("R5 disabled no offer");
    enable = 1;
    s_eo = 1; step("R7 edge eoi no pulse");
    step("R7 after edge eoi");
    rq(8'hC1, 1); step("R8 level request");
    ak(8'hC1); step("R6 ack C1");
    s_eo = 1; step("R7 level eoi");
    step("R7 pulse one cycle");
    rq(8'h77, 0); step("R8 edge 77");
    rq(8'h77, 1); step("R8 dup level dropped");
    ak(8'h77); step("R8 ack 77");
    s_eo = 1; step("R8 eoi no pulse");
    step("R8 after eoi");
    rq(8'hE0, 1); ak(8'hE0); s_eo = 1; step("R11 same-cycle req ack eoi");
    step("R11 after");
    tw(32'h0); step("R3 tpr zero");
    ak(8'h95); step("R6 ack 95");
    ak(8'h52); step("R6 ack 52");
    s_eo = 1; step("R7 retire 95");
    s_eo = 1; step("R7 retire 52");
    step("R2 idle end");
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule